// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block turns the operand address of an 8-bit core into a physical target in a data space with two banks. Each bank has a 7-bit offset range. The low offsets of each bank hold special-function registers (SFRs), and the SFRs of the two banks are separate. A window of general-purpose bytes follows them. That window is backed by a single 68-byte static RAM inside the block, so both banks reach the same storage. Offsets above the window have no storage behind them.

Offset 00h is a virtual register. An access to it does not touch offset 00h. It is redirected through an 8-bit pointer: the low seven pointer bits give the offset and the current bank bit gives the bank. If the pointer names offset 00h itself, the access goes nowhere. A second bank bit is accepted at the port but plays no part in decoding.

Decoding is combinational. The general-purpose RAM is written on the rising clock edge. SFR contents live outside the block, which only supplies the banked SFR address, the strobes and a read path.

Top module: `dmd_bank_decoder`

## Requirements
- R1: An access that decodes to an SFR offset (01h..0Bh) asserts `sfr_sel` and presents `sfr_addr` = {`bank_sel`, offset}. Bit 7 of `sfr_addr` is the bank.
- R2: `bank_hi` has no effect on any output or on RAM contents.
- R3: Offsets 0Ch..4Fh select the general-purpose RAM with `ram_idx` = offset − 0Ch in either bank. A byte written through bank 1 reads back through bank 0 at the same offset.
- R4: A direct offset of 00h selects indirect mode. The effective offset is `ind_ptr[6:0]` and the bank is `bank_sel`. `ind_ptr[7]` is ignored.
- R5: An indirect access whose `ind_ptr[6:0]` is 00h selects nothing. `rd_data` is 0, and no RAM or SFR write occurs.
- R6: Offsets 50h..7Fh select nothing. They read 0, and writes to them change no stored byte.
- R7: `ram_we` equals `wr_en` while the RAM is selected. The byte is stored at the next rising edge and reads back combinationally after that edge.
- R8: `sfr_re` = `rd_en` and `sfr_we` = `wr_en` while an SFR is selected, and both are 0 otherwise. `rd_data` follows `sfr_rdata` while an SFR is selected.
- R9: A rising edge with `rst_n` low clears every general-purpose RAM byte to 0.
- R10: `ram_sel` and `sfr_sel` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_ofs | input | 7 | Direct offset from the instruction |
| ind_ptr | input | 8 | Indirect pointer register value |
| bank_sel | input | 1 | Bank bit: 1 selects bank 1 |
| bank_hi | input | 1 | Upper bank bit, kept clear by software, ignored |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| sfr_rdata | input | 8 | Read data returned by the SFR file |
| rd_data | output | 8 | Read data of the decoded target |
| ram_sel | output | 1 | General-purpose RAM selected |
| ram_idx | output | 7 | Physical RAM byte index |
| ram_we | output | 1 | RAM write enable |
| sfr_sel | output | 1 | SFR selected |
| sfr_addr | output | 8 | Banked SFR address {bank, offset} |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |

## Verification
Random accesses draw direct offsets from every region, including 00h, so the SFR, RAM, empty and indirect paths are all exercised. Pointer values, both bank bits and both strobes are also random, and a byte model predicts every read. Directed cases probe the region edges 0Bh/0Ch, 4Fh/50h and 7Fh. Separate cases distinguish a pointer to 00h from a pointer to a real offset, and a pointer with bit 7 set from one with bit 7 clear. A write through bank 1 is read through bank 0 to tell mirroring apart from per-bank storage. A reset is taken after RAM writes to show that the storage is cleared.

// File: rtl/dmd_pkg.sv
// Package: shared types of the banked data memory decoder.
// Assumes: two banks, one region kind per access.
package dmd_pkg;

    // Region an effective offset falls into.
    typedef enum logic [1:0] {
        RG_NONE = 2'd0,   // nothing behind the offset
        RG_NULL = 2'd1,   // virtual register reached through the pointer
        RG_SFR  = 2'd2,   // banked special-function register
        RG_GPR  = 2'd3    // shared general-purpose RAM
    } region_e;

endpackage

// File: rtl/dmd_addr_mux.sv
// Module: dmd_addr_mux
// Forms the effective (bank, offset) pair of one access. A direct offset
// equal to IND_OFS switches to indirect mode, where the low pointer bits
// give the offset. The bank bit applies in both modes.
// Assumes: PTR_W > OFS_W; pointer bits above OFS_W carry no meaning here.
module dmd_addr_mux #(
    parameter int OFS_W  = 7,
    parameter int PTR_W  = 8,
    parameter int IND_OFS = 0
) (
    input  logic [OFS_W-1:0] dir_ofs,
    input  logic [PTR_W-1:0] ind_ptr,
    input  logic             bank_sel,
    output logic [OFS_W-1:0] eff_ofs,
    output logic             eff_bank,
    output logic             ind_mode
);

    localparam logic [OFS_W-1:0] IND_CODE = OFS_W'(IND_OFS);

    logic unused_ptr_hi;
    assign unused_ptr_hi = ^ind_ptr[PTR_W-1:OFS_W];

    // Pick the offset source and carry the bank bit through.
    always_comb begin
        ind_mode = (dir_ofs == IND_CODE);
        eff_ofs  = ind_mode ? ind_ptr[OFS_W-1:0] : dir_ofs;
        eff_bank = bank_sel;
    end

endmodule

// File: rtl/dmd_region_dec.sv
// Module: dmd_region_dec
// Classifies an effective offset into a region and gives the RAM index.
// Offsets below GPR_LO are SFRs except IND_OFS, the window
// [GPR_LO, GPR_LO+GPR_CNT) is RAM, and the rest is empty.
// Assumes: IND_OFS < GPR_LO and GPR_LO+GPR_CNT <= 2**OFS_W.
module dmd_region_dec
    import dmd_pkg::*;
#(
    parameter int OFS_W   = 7,
    parameter int IND_OFS = 0,
    parameter int GPR_LO  = 12,
    parameter int GPR_CNT = 68,
    parameter int IDX_W   = $clog2(GPR_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] eff_ofs,
    output region_e          region,
    output logic [IDX_W-1:0] gpr_idx
);

    localparam int GPR_END = GPR_LO + GPR_CNT;

    // Range compare of the offset against the region limits.
    always_comb begin
        gpr_idx = IDX_W'(int'(eff_ofs) - GPR_LO);
        if (int'(eff_ofs) == IND_OFS) begin
            region = RG_NULL;
        end else if (int'(eff_ofs) < GPR_LO) begin
            region = RG_SFR;
        end else if (int'(eff_ofs) < GPR_END) begin
            region = RG_GPR;
        end else begin
            region = RG_NONE;
        end
    end

    AST_EMPTY_ABOVE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(eff_ofs) >= GPR_END) |-> (region == RG_NONE)); // R6

endmodule

// File: rtl/dmd_gpr_ram.sv
// Module: dmd_gpr_ram
// Shared general-purpose byte storage. Write on the rising edge, read
// combinational, cleared by synchronous reset. Out-of-range indices read
// zero and never write.
// Assumes: the caller gates we with its own select.
module dmd_gpr_ram #(
    parameter int DEPTH = 68,
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = (int'(idx) < DEPTH);

    // Clear on reset, otherwise store the write byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we && in_range) begin
            mem[idx] <= wdata;
        end
    end

    // Combinational read port.
    always_comb begin
        rdata = in_range ? mem[idx] : '0;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((idx != $past(idx)) || (rdata == $past(wdata)))); // R7

endmodule

// File: rtl/dmd_bank_decoder.sv
// Module: dmd_bank_decoder (top)
// Decodes one data-memory access of an 8-bit core with two banks onto the
// banked SFR file (outside) or the shared general-purpose RAM (inside),
// resolving the virtual indirect register through the pointer.
// Assumes: bank_hi is kept clear and is ignored; SFR data is returned
// combinationally on sfr_rdata.
module dmd_bank_decoder
    import dmd_pkg::*;
#(
    parameter int OFS_W   = 7,
    parameter int PTR_W   = 8,
    parameter int DW      = 8,
    parameter int IND_OFS = 0,
    parameter int GPR_LO  = 12,
    parameter int GPR_CNT = 68,
    parameter int IDX_W   = $clog2(GPR_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] dir_ofs,
    input  logic [PTR_W-1:0] ind_ptr,
    input  logic             bank_sel,
    input  logic             bank_hi,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    sfr_rdata,
    output logic [DW-1:0]    rd_data,
    output logic             ram_sel,
    output logic [IDX_W-1:0] ram_idx,
    output logic             ram_we,
    output logic             sfr_sel,
    output logic [OFS_W:0]   sfr_addr,
    output logic             sfr_re,
    output logic             sfr_we
);

    logic [OFS_W-1:0] eff_ofs;
    logic             eff_bank;
    logic             ind_mode;
    region_e          region;
    logic [IDX_W-1:0] gpr_idx;
    logic [DW-1:0]    ram_rdata;
    logic             unused_bank_hi;

    assign unused_bank_hi = bank_hi;

    dmd_addr_mux #(
        .OFS_W   (OFS_W),
        .PTR_W   (PTR_W),
        .IND_OFS (IND_OFS)
    ) i_addr_mux (
        .dir_ofs  (dir_ofs),
        .ind_ptr  (ind_ptr),
        .bank_sel (bank_sel),
        .eff_ofs  (eff_ofs),
        .eff_bank (eff_bank),
        .ind_mode (ind_mode)
    );

    dmd_region_dec #(
        .OFS_W   (OFS_W),
        .IND_OFS (IND_OFS),
        .GPR_LO  (GPR_LO),
        .GPR_CNT (GPR_CNT),
        .IDX_W   (IDX_W)
    ) i_region_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .eff_ofs (eff_ofs),
        .region  (region),
        .gpr_idx (gpr_idx)
    );

    dmd_gpr_ram #(
        .DEPTH (GPR_CNT),
        .DW    (DW),
        .IDX_W (IDX_W)
    ) i_gpr_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (wr_data),
        .rdata (ram_rdata)
    );

    // Target selects and strobes from the decoded region.
    always_comb begin
        ram_sel  = (region == RG_GPR);
        sfr_sel  = (region == RG_SFR);
        ram_idx  = gpr_idx;
        ram_we   = ram_sel && wr_en;
        sfr_addr = {eff_bank, eff_ofs};
        sfr_re   = sfr_sel && rd_en;
        sfr_we   = sfr_sel && wr_en;
    end

    // Read data mux; empty and null regions return zero.
    always_comb begin
        unique case (region)
            RG_GPR:  rd_data = ram_rdata;
            RG_SFR:  rd_data = sfr_rdata;
            default: rd_data = '0;
        endcase
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, sfr_sel})); // R10
    AST_SFR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel |-> (sfr_addr[OFS_W] == bank_sel)); // R1
    AST_NULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_mode && (int'(ind_ptr[OFS_W-1:0]) == IND_OFS))
        |-> (!ram_we && !sfr_we && (rd_data == '0))); // R5

endmodule

// File: tb/test_dmd_bank_decoder.sv
module test_dmd_bank_decoder;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] dir_ofs = '0;
    logic [7:0] ind_ptr = '0;
    logic       bank_sel = 1'b0;
    logic       bank_hi = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] sfr_rdata = '0;
    logic [7:0] rd_data;
    logic       ram_sel;
    logic [6:0] ram_idx;
    logic       ram_we;
    logic       sfr_sel;
    logic [7:0] sfr_addr;
    logic       sfr_re;
    logic       sfr_we;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] mdl [68];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmd_bank_decoder i_dmd_bank_decoder (
        .clk(clk), .rst_n(rst_n), .dir_ofs(dir_ofs), .ind_ptr(ind_ptr),
        .bank_sel(bank_sel), .bank_hi(bank_hi), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .sfr_rdata(sfr_rdata), .rd_data(rd_data),
        .ram_sel(ram_sel), .ram_idx(ram_idx), .ram_we(ram_we),
        .sfr_sel(sfr_sel), .sfr_addr(sfr_addr), .sfr_re(sfr_re), .sfr_we(sfr_we)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Effective offset per the requirements (R4).
    function automatic logic [6:0] exp_ofs(input logic [6:0] d, input logic [7:0] p);
        return (d == 7'h00) ? p[6:0] : d;
    endfunction

    // One access: drive at the falling edge, check, then track the write.
    task automatic access(input logic [6:0] d, input logic [7:0] p, input logic b0,
                          input logic b1, input logic r, input logic w,
                          input logic [7:0] wd, input logic [7:0] sd, input string tag);
        logic [6:0] o;
        logic       e_sfr, e_gpr;
        logic [6:0] e_idx;
        logic [7:0] e_rd;
        @(negedge clk);
        dir_ofs = d; ind_ptr = p; bank_sel = b0; bank_hi = b1;
        rd_en = r; wr_en = w; wr_data = wd; sfr_rdata = sd;
        #1;
        o     = exp_ofs(d, p);
        e_sfr = (o != 7'h00) && (o < 7'h0C);
        e_gpr = (o >= 7'h0C) && (o < 7'h50);
        e_idx = o - 7'h0C;
        e_rd  = e_gpr ? mdl[e_idx] : (e_sfr ? sd : 8'h00);
        chk({14'b0, sfr_sel, ram_sel}, {14'b0, e_sfr, e_gpr}, {tag, " select R10"});
        if (e_sfr) chk({8'b0, sfr_addr}, {8'b0, b0, o}, {tag, " sfr_addr R1"});
        if (e_gpr) chk({9'b0, ram_idx}, {9'b0, e_idx}, {tag, " ram_idx R3"});
        chk({14'b0, sfr_re, sfr_we}, {14'b0, e_sfr & r, e_sfr & w}, {tag, " strobes R8"});
        chk({15'b0, ram_we}, {15'b0, e_gpr & w}, {tag, " ram_we R7"});
        chk({8'b0, rd_data}, {8'b0, e_rd}, {tag, " rd_data"});
        if (e_gpr && w) mdl[e_idx] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        foreach (mdl[i]) mdl[i] = 8'h00;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0D3C));
        foreach (mdl[i]) mdl[i] = 8'h00;
        do_reset();
        // Reset state
        access(7'h0C, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11, "R9 reset low byte");
        access(7'h4F, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11, "R9 reset high byte");
        // Region boundaries
        access(7'h0B, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hC3, "R1 last sfr bank1");
        access(7'h01, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h3C, "R8 first sfr bank0");
        access(7'h0C, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1, 8'h00, "R7 write first ram");
        access(7'h0C, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R7 read back");
        access(7'h4F, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hB2, 8'h00, "R3 last ram");
        access(7'h50, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hEE, 8'h77, "R6 first empty");
        access(7'h7F, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hEE, 8'h77, "R6 last empty");
        access(7'h4F, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R6 neighbour kept");
        // Mirroring: write via bank 1, read via bank 0
        access(7'h20, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h6D, 8'h00, "R3 bank1 write");
        access(7'h20, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R3 bank0 read");
        // Upper bank bit ignored
        access(7'h05, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h42, "R2 bank_hi sfr");
        access(7'h20, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R2 bank_hi ram");
        // Indirect
        access(7'h00, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R4 ptr bit7 set");
        access(7'h00, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1, 8'h19, 8'h00, "R4 ptr write");
        access(7'h00, 8'h83, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h9A, "R4 ptr to sfr");
        access(7'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h55, "R5 ptr to itself");
        access(7'h00, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h55, "R5 ptr to itself hi");
        access(7'h00, 8'hD5, 1'b0, 1'b0, 1'b1, 1'b1, 8'h33, 8'h55, "R6 ptr to empty");
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] d;
            case ($urandom_range(0, 4))
                0:       d = 7'h00;
                1:       d = 7'($urandom_range(1, 11));
                2:       d = 7'($urandom_range(80, 127));
                default: d = 7'($urandom_range(12, 79));
            endcase
            access(d, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 8'($urandom), 8'($urandom), "random R4");
        end
        // Reset clears stored bytes
        access(7'h30, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC7, 8'h00, "R7 pre-reset write");
        do_reset();
        access(7'h30, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R9 cleared");
        access(7'h20, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R9 cleared mirror");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule